// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Address-Mark Wakeup

This block recovers characters from an asynchronous NRZ serial line. The line idles at mark (high). A character begins with a falling edge into a space-level start bit. A fixed number of word slots follows, then one mark-level stop bit. An enable pulse, supplied from outside at sixteen times the bit rate, drives all timing. The receiver confirms the start bit at its centre and then samples every later slot once, at its centre.

The configuration inputs pick the format. A character holds eight or nine slots. When parity is on, the last slot carries the parity bit. Bits arrive either least or most significant first. The receiver puts the recovered bits back into their proper weights. It checks parity and the stop bit. It presents the word with a one-cycle strobe.

For multidrop links a wakeup mode is provided. Software pulses a sleep request, and from then on characters are dropped silently. The first character whose top data bit is set is treated as an address. That character ends the sleep and is delivered.

Top module: `serial_rx_wake`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_valid, rx_par_err, rx_frm_err and asleep are 0 and rx_data is all zeros.
- R2: A low level that has gone back to high before the centre of the start bit (8 oversampling ticks after the falling edge is seen) is rejected. It produces no character, and a normal character that follows is received correctly.
- R3: With cfg_nine=0 and parity off, eight data bits are recovered into rx_data[7:0], and rx_data[8] reads 0.
- R4: With parity on, the data count is the slot count minus one (7 or 8). The final slot is taken as parity and is not part of the word. Every rx_data bit at or above the data count reads 0.
- R5: With cfg_nine=1 and parity off, nine data bits are recovered into rx_data[8:0].
- R6: With cfg_msb_first=0 the first slot after the start bit is data bit 0. With cfg_msb_first=1 the first slot is the top data bit (data count minus one), and the following slots descend from there.
- R7: rx_par_err is 1 for a delivered character when parity is on and the count of ones over the data bits plus the parity slot is odd (cfg_par_odd=0) or even (cfg_par_odd=1). It is always 0 when parity is off.
- R8: A stop bit sampled at space sets rx_frm_err for that character. The character is still delivered with its data.
- R9: Each delivered character raises rx_valid for exactly one clock cycle. rx_data, rx_par_err and rx_frm_err keep their values until the next delivery.
- R10: A one-cycle sleep_req with cfg_wake_en=1 sets asleep in the next cycle. With cfg_wake_en=0, sleep_req leaves asleep at 0.
- R11: While asleep, a character whose top data bit (index data count minus one) is 0 is discarded. No rx_valid is raised, and rx_data and the flags are unchanged.
- R12: While asleep, a character whose top data bit is 1 clears asleep and is delivered with rx_valid.
- R13: Driving cfg_wake_en to 0 clears asleep in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1: nine word slots, 0: eight |
| cfg_par_en | input | 1 | Last slot is parity |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_msb_first | input | 1 | Slot order, 1: top data bit first |
| cfg_wake_en | input | 1 | Enables sleep/address-wakeup mode |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| rx_data | output | 9 | Recovered word, unused high bits zero |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| rx_par_err | output | 1 | Parity mismatch for the delivered character |
| rx_frm_err | output | 1 | Stop bit was space for the delivered character |
| asleep | output | 1 | Receiver is discarding non-address characters |

## Verification
Suppose the slot counter or the sample phase drifts by one step. The fault shows up on the very next character: bits land in the wrong weights, the parity check trips, or the sampled stop level is wrong. The strobe arrives within one bit time of the stop-bit centre. A wrong sleep state has a different signature. A character that should appear goes missing, or a non-address character comes through, and rx_data is either held or overwritten. This is seen within one character time. Random formats with random data compare every delivered word against bench-computed slot patterns. Directed cases cover glitches, each error, and the wakeup transitions.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_SLOT  = 2'd2,
    RX_STOP  = 2'd3
  } rx_phase_e;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer
  import serial_rx_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int MAX_SLOTS = 9,
  localparam int CW = $clog2(OSR),
  localparam int SW = $clog2(MAX_SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [SW-1:0] slots_total,
  output logic          slot_stb,
  output logic [SW-1:0] slot_idx,
  output logic          stop_stb
);

  localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OSR - 1);

  rx_phase_e     ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [SW-1:0] slot_q, slot_n;

  always_comb begin
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    slot_n   = slot_q;
    slot_stb = 1'b0;
    stop_stb = 1'b0;
    if (tick) begin
      unique case (ph_q)
        RX_IDLE: begin
          if (!line) begin
            ph_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == HALF_LAST) begin
            cnt_n  = '0;
            slot_n = '0;
            ph_n   = line ? RX_IDLE : RX_SLOT;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_SLOT: begin
          if (cnt_q == FULL_LAST) begin
            slot_stb = 1'b1;
            cnt_n    = '0;
            if (slot_q == slots_total - SW'(1)) ph_n = RX_STOP;
            else                                slot_n = slot_q + SW'(1);
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == FULL_LAST) begin
            stop_stb = 1'b1;
            cnt_n    = '0;
            ph_n     = RX_IDLE;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        default: ph_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= RX_IDLE;
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (tick) begin
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
      slot_q <= slot_n;
    end
  end

  assign slot_idx = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == RX_SLOT) |-> (slot_q < slots_total)); // R5

  AST_START_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == RX_START) |-> (cnt_q <= HALF_LAST)); // R2

endmodule

// File: rtl/srx_char_build.sv
module srx_char_build #(
  parameter int MAX_SLOTS = 9,
  localparam int SW = $clog2(MAX_SLOTS + 1),
  localparam int IW = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_stb,
  input  logic [SW-1:0]        slot_idx,
  input  logic                 line,
  input  logic [SW-1:0]        slots_total,
  input  logic                 par_en,
  input  logic                 par_odd,
  input  logic                 msb_first,
  output logic [MAX_SLOTS-1:0] word,
  output logic                 par_bad,
  output logic                 addr_mark
);

  logic [MAX_SLOTS-1:0] raw_q, raw_n;
  logic [SW-1:0]        ndata;
  logic                 par_slot;

  always_comb begin
    raw_n = raw_q;
    if (slot_stb) raw_n[IW'(slot_idx)] = line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raw_q <= '0;
    else if (slot_stb) raw_q <= raw_n;
  end

  assign ndata = slots_total - SW'(par_en);

  always_comb begin
    word = '0;
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (i < int'(ndata)) begin
        if (msb_first) word[i] = raw_q[IW'(int'(ndata) - 1 - i)];
        else           word[i] = raw_q[i];
      end
    end
  end

  assign par_slot  = raw_q[IW'(slots_total - SW'(1))];
  assign par_bad   = par_en & ((^word) ^ par_slot ^ par_odd);
  assign addr_mark = word[IW'(ndata - SW'(1))];

endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake #(
  parameter int OSR       = 16,
  parameter int MAX_SLOTS = 9,
  parameter int SYNC_FF   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick16,
  input  logic                 rxd,
  input  logic                 cfg_nine,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_odd,
  input  logic                 cfg_msb_first,
  input  logic                 cfg_wake_en,
  input  logic                 sleep_req,
  output logic [MAX_SLOTS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_par_err,
  output logic                 rx_frm_err,
  output logic                 asleep
);

  localparam int SW = $clog2(MAX_SLOTS + 1);

  logic                 line_s;
  logic [SW-1:0]        slots_total;
  logic                 slot_stb, stop_stb;
  logic [SW-1:0]        slot_idx;
  logic [MAX_SLOTS-1:0] word;
  logic                 par_bad, addr_mark;
  logic                 deliver;

  logic [MAX_SLOTS-1:0] data_n;
  logic                 valid_n, pe_n, fe_n, asleep_n;

  assign slots_total = cfg_nine ? SW'(MAX_SLOTS) : SW'(MAX_SLOTS - 1);

  srx_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  srx_bit_timer #(.OSR(OSR), .MAX_SLOTS(MAX_SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .slots_total(slots_total), .slot_stb(slot_stb),
    .slot_idx(slot_idx), .stop_stb(stop_stb)
  );

  srx_char_build #(.MAX_SLOTS(MAX_SLOTS)) u_build (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_idx(slot_idx),
    .line(line_s), .slots_total(slots_total), .par_en(cfg_par_en),
    .par_odd(cfg_par_odd), .msb_first(cfg_msb_first), .word(word),
    .par_bad(par_bad), .addr_mark(addr_mark)
  );

  assign deliver = stop_stb & (~asleep | addr_mark);

  always_comb begin
    valid_n  = deliver;
    data_n   = rx_data;
    pe_n     = rx_par_err;
    fe_n     = rx_frm_err;
    asleep_n = asleep;
    if (deliver) begin
      data_n = word;
      pe_n   = par_bad;
      fe_n   = ~line_s;
    end
    if (!cfg_wake_en)                         asleep_n = 1'b0;
    else if (sleep_req)                       asleep_n = 1'b1;
    else if (stop_stb && asleep && addr_mark) asleep_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      asleep     <= 1'b0;
    end else begin
      rx_valid   <= valid_n;
      rx_data    <= data_n;
      rx_par_err <= pe_n;
      rx_frm_err <= fe_n;
      asleep     <= asleep_n;
    end
  end

  int top_idx;
  assign top_idx = int'(slots_total) - int'(cfg_par_en) - 1;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R9

  AST_SLEEP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wake_en && sleep_req) |=> asleep); // R10

  AST_WAKE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wake_en |=> !asleep); // R13

  AST_WAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(asleep)) |-> rx_data[top_idx]); // R12

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_nine) |-> !rx_data[MAX_SLOTS-1]); // R3

endmodule

// File: tb/serial_rx_wake_tb_top.sv
module serial_rx_wake_tb_top;

  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_msb_first = 1'b0, cfg_wake_en = 1'b0, sleep_req = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err, asleep;

  int tests = 0, fails = 0, vcount = 0;
  logic [8:0] cap_data = '0;
  logic cap_pe = 1'b0, cap_fe = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  always @(posedge clk) begin
    if (rx_valid) begin
      vcount   <= vcount + 1;
      cap_data <= rx_data;
      cap_pe   <= rx_par_err;
      cap_fe   <= rx_frm_err;
    end
  end

  serial_rx_wake dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_msb_first(cfg_msb_first), .cfg_wake_en(cfg_wake_en),
    .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .asleep(asleep)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ndata();
    return (cfg_nine ? 9 : 8) - int'(cfg_par_en);
  endfunction

  function automatic logic [8:0] mask_word(input logic [8:0] d);
    logic [8:0] m = '0;
    for (int i = 0; i < ndata(); i++) m[i] = d[i];
    return m;
  endfunction

  function automatic logic [8:0] slot_bits(input logic [8:0] d, input bit bad_par);
    logic [8:0] s = '0;
    logic [8:0] dm = mask_word(d);
    int n = ndata();
    for (int i = 0; i < n; i++) s[i] = cfg_msb_first ? dm[n-1-i] : dm[i];
    if (cfg_par_en) s[n] = (^dm) ^ cfg_par_odd ^ bad_par;
    return s;
  endfunction

  task automatic send(input logic [8:0] d, input bit bad_par, input bit bad_stop);
    logic [8:0] s = slot_bits(d, bad_par);
    int ns = cfg_nine ? 9 : 8;
    @(negedge clk) rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < ns; i++) begin
      rxd = s[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = ~bad_stop;
    repeat (bad_stop ? 24 : BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic frame_check(input logic [8:0] d, input bit bad_par,
                             input bit bad_stop, input string req);
    int v0 = vcount;
    logic [8:0] exp = mask_word(d);
    send(d, bad_par, bad_stop);
    check(vcount == v0 + 1, req, vcount - v0, 1);
    check(cap_data == exp, req, int'(cap_data), int'(exp));
    check(cap_pe == (bad_par & cfg_par_en), {req, "/R7"}, int'(cap_pe), int'(bad_par & cfg_par_en));
    check(cap_fe == bad_stop, {req, "/R8"}, int'(cap_fe), int'(bad_stop));
  endtask

  task automatic set_cfg(input bit nine, input bit pen, input bit podd, input bit msb);
    @(negedge clk);
    cfg_nine = nine; cfg_par_en = pen; cfg_par_odd = podd; cfg_msb_first = msb;
  endtask

  task automatic pulse_sleep();
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk) sleep_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v0;
    logic [8:0] held;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check(!rx_valid && !asleep && rx_data == 0 && !rx_par_err && !rx_frm_err,
          "R1 in reset", int'(rx_data), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(!rx_valid && !asleep && rx_data == 0, "R1 after release", int'(rx_data), 0);
    repeat (20) @(negedge clk);

    // R3 / R6 eight data bits, both orders
    set_cfg(0, 0, 0, 0);
    frame_check(9'h0A5, 0, 0, "R3 lsb");
    frame_check(9'h013, 0, 0, "R3 lsb2");
    set_cfg(0, 0, 0, 1);
    frame_check(9'h0C1, 0, 0, "R6 msb8");
    // R5 nine bits
    set_cfg(1, 0, 0, 0);
    frame_check(9'h1A3, 0, 0, "R5 lsb9");
    set_cfg(1, 0, 0, 1);
    frame_check(9'h10E, 0, 0, "R6 msb9");
    // R4 parity formats
    set_cfg(0, 1, 0, 0);
    frame_check(9'h05B, 0, 0, "R4 7p even");
    set_cfg(0, 1, 1, 1);
    frame_check(9'h041, 0, 0, "R4 7p odd msb");
    set_cfg(1, 1, 0, 1);
    frame_check(9'h0F0, 0, 0, "R4 8p msb");
    // R7 parity errors
    set_cfg(0, 1, 0, 0);
    frame_check(9'h033, 1, 0, "R7 even bad");
    set_cfg(1, 1, 1, 0);
    frame_check(9'h0AA, 1, 0, "R7 odd bad");
    // R8 framing error
    set_cfg(0, 0, 0, 0);
    frame_check(9'h05A, 0, 1, "R8 stop low");

    // R2 glitch rejection
    v0 = vcount;
    @(negedge clk) rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check(vcount == v0, "R2 glitch", vcount - v0, 0);
    frame_check(9'h0E7, 0, 0, "R2 after glitch");

    // R10 ignored when wake disabled
    pulse_sleep();
    check(!asleep, "R10 wake off", int'(asleep), 0);
    @(negedge clk) cfg_wake_en = 1'b1;
    pulse_sleep();
    check(asleep, "R10 enter", int'(asleep), 1);

    // R11 discard non-address
    held = rx_data;
    v0 = vcount;
    send(9'h07F, 0, 0);
    check(vcount == v0, "R11 discard", vcount - v0, 0);
    check(rx_data == held, "R11 data held", int'(rx_data), int'(held));
    check(asleep, "R11 still asleep", int'(asleep), 1);
    // R12 address wakes
    frame_check(9'h085, 0, 0, "R12 addr");
    check(!asleep, "R12 awake", int'(asleep), 0);
    // R9 hold after delivery
    repeat (50) @(negedge clk);
    check(rx_data == 9'h085 && !rx_valid, "R9 hold", int'(rx_data), 9'h085);
    // R12 in nine-bit mode uses bit 8
    set_cfg(1, 0, 0, 1);
    pulse_sleep();
    v0 = vcount;
    send(9'h0FF, 0, 0);
    check(vcount == v0, "R11 nine discard", vcount - v0, 0);
    frame_check(9'h100, 0, 0, "R12 nine addr");
    // R13 disabling wake clears sleep
    pulse_sleep();
    @(negedge clk) cfg_wake_en = 1'b0;
    @(negedge clk);
    check(!asleep, "R13 clear", int'(asleep), 0);

    // random formats and data
    for (int k = 0; k < 40; k++) begin
      set_cfg($urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 1));
      frame_check(9'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                  "R6 random");
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule